// File: doc/BRIEF.md
# Triple-Lane Majority-Voted Register Pipeline

This block is a data pipeline meant to keep working when a single storage element flips state. Every register stage is built three times, as lanes A, B and C. Each lane has its own clock and its own reset, so a fault on one clock or reset net touches only one copy. After every stage a majority voter combines the three copies. Each lane has its own voter, and that voter feeds the next stage of the same lane. A single corrupted register is therefore outvoted before the next edge stores it, and the error cannot travel down the pipeline or pile up.

Each lane drives its own output, taken from its voter on the last stage. A per-stage disagreement vector is provided for test. Per-lane, per-stage inversion masks let a testbench flip any chosen register bit on a chosen edge.

Depth and data width are parameters. The default is 4 stages of 8 bits.

Top module: `tmr_pipe`

## Requirements
- R1: Each lane has an asynchronous, active-high reset that clears only that lane's registers. While all three resets are high, out_a, out_b and out_c are 0 and mismatch is 0.
- R2: On a rising edge, stage 0 of lane X stores din_X XOR bits [WIDTH-1:0] of upset_X. When the three lanes get equal inputs and no upsets, each output equals the input applied DEPTH rising edges earlier.
- R3: When the lane inputs differ, every output carries the bitwise majority (a&b)|(b&c)|(a&c) of the three stage-0 values, DEPTH edges later.
- R4: Stage k+1 of each lane stores its own lane's voted value of stage k, XOR bits [(k+1)*WIDTH +: WIDTH] of upset_X, where a 1 inverts the stored bit. A one-edge upset of a single bit in a single lane at any stage never changes any output.
- R5: mismatch[k] is high exactly while the stage-k registers of the three lanes are not all equal. A single-lane upset at stage k for one edge raises mismatch[k] for exactly one cycle.
- R6: A single-lane upset does not spread. While it is present, every mismatch bit other than bit k stays 0. One edge later, all mismatch bits are 0.
- R7: Holding one lane in reset while data flows leaves all three outputs correct. One rising edge after that reset is released, every mismatch bit is 0.
- R8: If two lanes flip the same bit at the same stage k on the same edge, the majority takes the corrupt value. That bit appears inverted on all outputs for one cycle, DEPTH-1-k edges after the upset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of lane A |
| clk_b | input | 1 | Clock of lane B |
| clk_c | input | 1 | Clock of lane C |
| rst_a | input | 1 | Asynchronous active-high reset of lane A |
| rst_b | input | 1 | Asynchronous active-high reset of lane B |
| rst_c | input | 1 | Asynchronous active-high reset of lane C |
| din_a | input | WIDTH | Data input of lane A |
| din_b | input | WIDTH | Data input of lane B |
| din_c | input | WIDTH | Data input of lane C |
| upset_a | input | DEPTH*WIDTH | Test inversion mask for lane A; slice k targets stage k |
| upset_b | input | DEPTH*WIDTH | Test inversion mask for lane B |
| upset_c | input | DEPTH*WIDTH | Test inversion mask for lane C |
| out_a | output | WIDTH | Voted last-stage output of lane A |
| out_b | output | WIDTH | Voted last-stage output of lane B |
| out_c | output | WIDTH | Voted last-stage output of lane C |
| mismatch | output | DEPTH | Per-stage flag: the three lane registers disagree |

## Verification
Every 8-bit value is fed, equal on all three lanes, to confirm the DEPTH-edge latency and plain data transfer. Lane inputs that differ, with one lane or a mix of bits disagreeing, separate a true per-bit majority from one that simply passes a single lane through. A sweep flips every bit of every register in every lane once and checks that outputs never move, while only the upset stage's flag rises for one cycle. This tells correction at the next stage apart from voting only at the output. Holding one lane in reset, and then flipping two lanes at once, shows where the redundancy stops: the first is masked, and the second comes out at the predicted cycle.

// File: rtl/tmr_pipe_pkg.sv
package tmr_pipe_pkg;
    localparam int NUM_LANES = 3;
    localparam int LANE_A    = 0;
    localparam int LANE_B    = 1;
    localparam int LANE_C    = 2;
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] c,
    output logic [WIDTH-1:0] y
);
    // bitwise two-of-three
    always_comb begin
        y = (a & b) | (b & c) | (a & c);
    end
endmodule

// File: rtl/tmr_lane.sv
module tmr_lane #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [WIDTH-1:0]             din,
    input  logic [DEPTH-1:0][WIDTH-1:0]  vote_in,
    input  logic [DEPTH-1:0][WIDTH-1:0]  upset,
    output logic [DEPTH-1:0][WIDTH-1:0]  stage_q
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] stage;
    } lane_state_t;

    lane_state_t state_d;
    lane_state_t state_q;

    always_comb begin
        state_d.stage[0] = din ^ upset[0];
        for (int k = 1; k < DEPTH; k++) begin
            state_d.stage[k] = vote_in[k-1] ^ upset[k];
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stage_q = state_q.stage;
endmodule

// File: rtl/tmr_mismatch.sv
module tmr_mismatch #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0][WIDTH-1:0] lane_a,
    input  logic [DEPTH-1:0][WIDTH-1:0] lane_b,
    input  logic [DEPTH-1:0][WIDTH-1:0] lane_c,
    output logic [DEPTH-1:0]            differ
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        assign differ[s] = (lane_a[s] != lane_b[s]) || (lane_b[s] != lane_c[s]);
    end
endmodule

// File: rtl/tmr_pipe.sv
module tmr_pipe
    import tmr_pipe_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic                     clk_a,
    input  logic                     clk_b,
    input  logic                     clk_c,
    input  logic                     rst_a,
    input  logic                     rst_b,
    input  logic                     rst_c,
    input  logic [WIDTH-1:0]         din_a,
    input  logic [WIDTH-1:0]         din_b,
    input  logic [WIDTH-1:0]         din_c,
    input  logic [DEPTH*WIDTH-1:0]   upset_a,
    input  logic [DEPTH*WIDTH-1:0]   upset_b,
    input  logic [DEPTH*WIDTH-1:0]   upset_c,
    output logic [WIDTH-1:0]         out_a,
    output logic [WIDTH-1:0]         out_b,
    output logic [WIDTH-1:0]         out_c,
    output logic [DEPTH-1:0]         mismatch
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0][WIDTH-1:0] lane_q  [NUM_LANES];
    logic [DEPTH-1:0][WIDTH-1:0] vote    [NUM_LANES];
    logic [DEPTH-1:0][WIDTH-1:0] upset_l [NUM_LANES];
    logic [WIDTH-1:0]            din_l   [NUM_LANES];
    logic                        clk_l   [NUM_LANES];
    logic                        rst_l   [NUM_LANES];

    assign clk_l[LANE_A]   = clk_a;
    assign clk_l[LANE_B]   = clk_b;
    assign clk_l[LANE_C]   = clk_c;
    assign rst_l[LANE_A]   = rst_a;
    assign rst_l[LANE_B]   = rst_b;
    assign rst_l[LANE_C]   = rst_c;
    assign din_l[LANE_A]   = din_a;
    assign din_l[LANE_B]   = din_b;
    assign din_l[LANE_C]   = din_c;
    assign upset_l[LANE_A] = upset_a;
    assign upset_l[LANE_B] = upset_b;
    assign upset_l[LANE_C] = upset_c;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        tmr_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_lane (
            .clk     (clk_l[l]),
            .rst     (rst_l[l]),
            .din     (din_l[l]),
            .vote_in (vote[l]),
            .upset   (upset_l[l]),
            .stage_q (lane_q[l])
        );
        for (genvar s = 0; s < DEPTH; s++) begin : g_vote
            tmr_voter #(.WIDTH(WIDTH)) u_voter (
                .a (lane_q[LANE_A][s]),
                .b (lane_q[LANE_B][s]),
                .c (lane_q[LANE_C][s]),
                .y (vote[l][s])
            );
        end
    end

    tmr_mismatch #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mismatch (
        .lane_a (lane_q[LANE_A]),
        .lane_b (lane_q[LANE_B]),
        .lane_c (lane_q[LANE_C]),
        .differ (mismatch)
    );

    assign out_a = vote[LANE_A][LAST];
    assign out_b = vote[LANE_B][LAST];
    assign out_c = vote[LANE_C][LAST];
endmodule

// File: rtl/tmr_pipe_checker.sv
module tmr_pipe_checker #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input logic                        clk,
    input logic                        rst_any,
    input logic [WIDTH-1:0]            din_a,
    input logic [WIDTH-1:0]            din_b,
    input logic [WIDTH-1:0]            din_c,
    input logic [DEPTH-1:0][WIDTH-1:0] ua,
    input logic [DEPTH-1:0][WIDTH-1:0] ub,
    input logic [DEPTH-1:0][WIDTH-1:0] uc,
    input logic [DEPTH-1:0][WIDTH-1:0] lane_a,
    input logic [DEPTH-1:0][WIDTH-1:0] lane_b,
    input logic [DEPTH-1:0][WIDTH-1:0] lane_c,
    input logic [WIDTH-1:0]            out_a,
    input logic [WIDTH-1:0]            out_b,
    input logic [WIDTH-1:0]            out_c,
    input logic [DEPTH-1:0]            mismatch
);
    // R2: lane A stage 0 stores the masked input of the previous edge
    p_stage0_capture_r2: assert property (@(posedge clk) disable iff (rst_any)
        !rst_any |=> lane_a[0] == $past(din_a ^ ua[0]));

    // R4: voted data makes stage k+1 agree across lanes when it is not upset
    for (genvar k = 0; k < DEPTH - 1; k++) begin : g_heal
        p_vote_heals_r4: assert property (@(posedge clk) disable iff (rst_any)
            (!rst_any && ua[k+1] == '0 && ub[k+1] == '0 && uc[k+1] == '0)
            |=> (lane_a[k+1] == lane_b[k+1] && lane_b[k+1] == lane_c[k+1]));
    end

    // R6: an agreeing pipeline with clean equal inputs stays agreeing
    p_clean_hold_r6: assert property (@(posedge clk) disable iff (rst_any)
        (!rst_any && mismatch == '0 && din_a == din_b && din_b == din_c
         && ua == '0 && ub == '0 && uc == '0) |=> mismatch == '0);

    // R5: an agreeing last stage is what every output presents
    p_out_follows_r5: assert property (@(posedge clk) disable iff (rst_any)
        !mismatch[DEPTH-1] |-> (out_a == lane_a[DEPTH-1] && out_b == lane_b[DEPTH-1]
                                && out_c == lane_c[DEPTH-1]));
endmodule

bind tmr_pipe tmr_pipe_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tmr_pipe_checker (
    .clk      (clk_a),
    .rst_any  (rst_a | rst_b | rst_c),
    .din_a    (din_a),
    .din_b    (din_b),
    .din_c    (din_c),
    .ua       (upset_a),
    .ub       (upset_b),
    .uc       (upset_c),
    .lane_a   (lane_q[0]),
    .lane_b   (lane_q[1]),
    .lane_c   (lane_q[2]),
    .out_a    (out_a),
    .out_b    (out_b),
    .out_c    (out_c),
    .mismatch (mismatch)
);

// File: tb/tmr_pipe_bench.sv
module tmr_pipe_bench;
    localparam int W = 8;
    localparam int D = 4;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_a = 1'b1, rst_b = 1'b1, rst_c = 1'b1;
    logic [W-1:0] din_a = '0, din_b = '0, din_c = '0;
    logic [D*W-1:0] up_a = '0, up_b = '0, up_c = '0;
    logic [W-1:0] out_a, out_b, out_c;
    logic [D-1:0] mismatch;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] v [D];
    logic [D-1:0] mis_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_pipe #(.WIDTH(W), .DEPTH(D)) u_tmr_pipe (
        .clk_a(clk), .clk_b(clk), .clk_c(clk),
        .rst_a(rst_a), .rst_b(rst_b), .rst_c(rst_c),
        .din_a(din_a), .din_b(din_b), .din_c(din_c),
        .upset_a(up_a), .upset_b(up_b), .upset_c(up_c),
        .out_a(out_a), .out_b(out_b), .out_c(out_c),
        .mismatch(mismatch)
    );

    function automatic logic [W-1:0] maj(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        return (a & b) | (b & c) | (a & c);
    endfunction

    // advance the reference model by one edge, then compare at the negedge
    task automatic cyc(input string tag);
        logic [W-1:0] xa, xb, xc, src;
        @(negedge clk);
        for (int i = D - 1; i >= 0; i--) begin
            src = (i == 0) ? din_a : v[i-1];
            xa = rst_a ? '0 : ((i == 0 ? din_a : src) ^ up_a[i*W +: W]);
            xb = rst_b ? '0 : ((i == 0 ? din_b : src) ^ up_b[i*W +: W]);
            xc = rst_c ? '0 : ((i == 0 ? din_c : src) ^ up_c[i*W +: W]);
            v[i] = maj(xa, xb, xc);
            mis_exp[i] = (xa != xb) || (xb != xc);
        end
        checks++;
        if (out_a !== v[D-1] || out_b !== v[D-1] || out_c !== v[D-1]) begin
            fails++;
            $display("FAIL %s outputs: got %h %h %h expected %h", tag, out_a, out_b, out_c, v[D-1]);
        end
        checks++;
        if (mismatch !== mis_exp) begin
            fails++;
            $display("FAIL %s mismatch: got %b expected %b", tag, mismatch, mis_exp);
        end
    endtask

    task automatic set_all(input logic [W-1:0] d);
        din_a = d; din_b = d; din_c = d;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < D; i++) v[i] = '0;
        // R1: reset state with data present at the inputs
        set_all(8'hA5);
        repeat (3) cyc("R1");
        @(negedge clk);
        rst_a = 1'b0; rst_b = 1'b0; rst_c = 1'b0;
        set_all('0);
        for (int i = 0; i < D; i++) v[i] = '0;

        // R2: every value, equal on all lanes
        for (int n = 0; n < 256 + D; n++) begin
            if (n < 256) set_all(W'(n)); else set_all('0);
            cyc("R2");
        end

        // R3: lanes disagree
        for (int n = 0; n < 64; n++) begin
            din_a = W'(n * 37);
            din_b = (n % 2 == 0) ? W'(n * 37) : W'(n * 11 + 3);
            din_c = W'(n * 91 + 7);
            cyc("R3");
        end
        set_all(8'hC3);
        repeat (D + 1) cyc("R3");

        // R4 R5 R6: single bit, single lane, every stage
        for (int l = 0; l < 3; l++) begin
            for (int k = 0; k < D; k++) begin
                for (int j = 0; j < W; j++) begin
                    case (l)
                        0: up_a[k*W + j] = 1'b1;
                        1: up_b[k*W + j] = 1'b1;
                        default: up_c[k*W + j] = 1'b1;
                    endcase
                    cyc("R5");
                    up_a = '0; up_b = '0; up_c = '0;
                    cyc("R6");
                    checks++;
                    if (out_a !== 8'hC3) begin
                        fails++;
                        $display("FAIL R4 out_a: got %h expected %h", out_a, 8'hC3);
                    end
                end
            end
        end

        // R7: lane B held in reset while data moves
        rst_b = 1'b1;
        for (int n = 0; n < 8; n++) begin
            set_all(W'(8'h10 + n * 5));
            cyc("R7");
        end
        rst_b = 1'b0;
        set_all(8'h3C);
        cyc("R7");
        checks++;
        if (mismatch !== '0) begin
            fails++;
            $display("FAIL R7 rejoin: got %b expected 0", mismatch);
        end
        repeat (D) cyc("R7");

        // R8: two lanes flip the same bit at stage 1
        up_a[1*W + 0] = 1'b1;
        up_b[1*W + 0] = 1'b1;
        cyc("R8");
        up_a = '0; up_b = '0;
        cyc("R8");
        cyc("R8");
        checks++;
        if (out_b !== (8'h3C ^ 8'h01)) begin
            fails++;
            $display("FAIL R8 corrupt bit: got %h expected %h", out_b, 8'h3C ^ 8'h01);
        end
        cyc("R8");
        checks++;
        if (out_c !== 8'h3C) begin
            fails++;
            $display("FAIL R8 recovery: got %h expected %h", out_c, 8'h3C);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule